// File: doc/BRIEF.md
# Clock configuration I2C target

This block is an I2C target that holds the configuration bytes of a system clock generator. A controller writes the bytes in one burst and reads them back in one burst over SCL and SDA at standard-mode rates (100 kbit/s or slower). The block samples both bus lines with a fast system clock. It drives SDA only through an open-drain enable: when `sda_oe` is 1, the pad pulls the line low.

A write starts with the target address byte 0xD2. The controller then sends two framing bytes, a command code and a byte count. The block acknowledges both and discards their values. Every byte after them is stored, starting at register 0 and moving upward. A read starts with the address byte 0xD3. The block returns the number of registers first, then the registers in ascending order.

Three of the registers drive the clock generator directly:
- Register 4 holds the enables for a group of miscellaneous clocks.
- Register 5 holds the enables for the PCI clocks.
- Register 6 holds the spread enable, the frequency code, the frequency-source select and the SDRAM reference enable.

Top module: `clkcfg_i2c_target`

## Requirements
- R1: After reset, registers 0 to 3 hold 0x00 and registers 4 and 5 hold 0xFF. Register 6 holds 0x21, which means spread off, frequency code 0b01000, strapped source selected and SDRAM reference enabled.
- R2: The address bytes 0xD2 (write) and 0xD3 (read) are acknowledged by pulling SDA low in the ninth clock. Any other address byte gets no acknowledge, and the bytes after it, up to the next START, are neither acknowledged nor stored.
- R3: In a write, the two bytes after the address are acknowledged and their values do not reach any register.
- R4: In a write, data bytes load register 0, then register 1, and so on. Each byte is acknowledged. A STOP after any complete byte leaves all later registers at their previous values.
- R5: `clk_en_misc` carries register 4. Bit 7 is reference clock 0, bit 6 the 24/48 MHz clock, bit 5 the 48 MHz clock, bit 4 graphics port clock 1, bit 3 graphics port clock 0, and bits 2..0 CPU pairs 2..0. A value of 1 means the clock is enabled.
- R6: `clk_en_pci` carries register 5. Bit 7 is reference clock 1 and bits 6..0 are PCI clocks 6..0.
- R7: Register 6 is decoded as follows. Bit 7 drives `spread_en`, bits 6:2 drive `freq_code`, bit 1 drives `freq_from_reg` and bit 0 drives `sdram_ref_en`.
- R8: A read returns the register count (7) first, then registers 0 to 6 in order, then 0xFF for every byte after register 6.
- R9: After the controller answers a read byte with a not-acknowledge, the target leaves SDA released.
- R10: A STOP that arrives before all eight bits of a data byte are in discards that byte. The register it would have loaded keeps its value.
- R11: Data bytes beyond register 6 are acknowledged and discarded.
- R12: A START without a preceding STOP restarts the address phase. A write may be followed directly by a read in this way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low |
| clk_en_misc | output | 8 | Register 4, miscellaneous clock enables |
| clk_en_pci | output | 8 | Register 5, reference clock 1 and PCI clock enables |
| spread_en | output | 1 | Register 6 bit 7 |
| freq_code | output | 5 | Register 6 bits 6:2 |
| freq_from_reg | output | 1 | Register 6 bit 1, 1 selects the register code over the strapped pins |
| sdram_ref_en | output | 1 | Register 6 bit 0 |

## Verification
Every bus event reaches the control logic about three system clocks after the pad changes: two synchronizer stages plus one edge-detect register. The acknowledge drive and each transmitted bit therefore appear on `sda_oe` about four cycles after the SCL falling edge that calls for them. A register output changes about four cycles after the SCL falling edge that ends its byte. The bench holds each SCL phase for 8 or 16 system clocks and samples SDA in the middle of the high phase, so every sample lands well after the design has settled. It checks the register outputs 20 cycles after the STOP.

// File: rtl/clkcfg_pkg.sv
// Package: shared constants, reset values and the link state type for the
// clock configuration I2C target. Assumes register indices 4..6 exist.
package clkcfg_pkg;

    localparam int CFG_REG_COUNT = 7;
    localparam int CFG_EN_MISC_IDX = 4;
    localparam int CFG_EN_PCI_IDX = 5;
    localparam int CFG_MODE_IDX = 6;
    localparam logic [6:0] CFG_DEV_ADDR = 7'h69; // 0xD2 write / 0xD3 read
    localparam logic [7:0] CFG_MODE_RESET = 8'h21;

    typedef enum logic [2:0] {
        LS_IDLE,
        LS_RX,
        LS_ACK,
        LS_TX,
        LS_ACK_IN
    } link_state_t;

    // Returns the power-on value of register idx.
    function automatic logic [7:0] cfg_reset_value(input int idx);
        if (idx == CFG_EN_MISC_IDX || idx == CFG_EN_PCI_IDX) begin
            return 8'hFF;
        end
        if (idx == CFG_MODE_IDX) begin
            return CFG_MODE_RESET;
        end
        return 8'h00;
    endfunction

endpackage

// File: rtl/clkcfg_bus_sampler.sv
// Bus sampler: brings SCL and SDA into the system clock domain through a
// synchronizer chain and derives SCL edges plus START and STOP events.
// Assumes the system clock runs far faster than SCL (dozens of samples per bit).
module clkcfg_bus_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_q;
    logic                   sda_q;

    // Synchronize both lines and keep one cycle of history; idle bus is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[SYNC_STAGES-1];
            sda_q    <= sda_pipe[SYNC_STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[SYNC_STAGES-1];
    assign sda_s     = sda_pipe[SYNC_STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/clkcfg_link.sv
// Link controller: byte framing, address match, acknowledge generation,
// transmit shifting and the byte position counter of a burst.
// Assumes events from clkcfg_bus_sampler; does not stretch SCL.
module clkcfg_link
    import clkcfg_pkg::*;
#(
    parameter int         NREG     = CFG_REG_COUNT,
    parameter logic [6:0] DEV_ADDR = CFG_DEV_ADDR,
    parameter int         POS_W    = $clog2(NREG + 3) + 1,
    parameter int         IDX_W    = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_s,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic [7:0]       rd_byte,
    output logic [POS_W-1:0] rd_pos,
    output logic             sda_oe,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data
);

    localparam logic [3:0] BITS = 4'd8;
    localparam logic [POS_W-1:0] FRAME_BYTES = POS_W'(2);

    link_state_t      state;
    logic [3:0]       bit_cnt;
    logic [7:0]       rx_shift;
    logic [7:0]       tx_shift;
    logic             is_addr;
    logic             rd_mode;
    logic [POS_W-1:0] byte_pos;
    logic [POS_W-1:0] data_pos;
    logic             pos_full;
    logic             data_slot;

    // Byte position decode: which register a received data byte belongs to.
    always_comb begin
        data_pos  = byte_pos - FRAME_BYTES;
        pos_full  = &byte_pos;
        data_slot = (byte_pos >= FRAME_BYTES) && (data_pos < POS_W'(NREG));
    end

    assign rd_pos = byte_pos;

    // Link sequencer: receive, acknowledge, transmit, sample controller ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= LS_IDLE;
            bit_cnt  <= '0;
            rx_shift <= '0;
            tx_shift <= '0;
            is_addr  <= 1'b0;
            rd_mode  <= 1'b0;
            byte_pos <= '0;
            sda_oe   <= 1'b0;
            wr_en    <= 1'b0;
            wr_idx   <= '0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                state    <= LS_RX;
                bit_cnt  <= '0;
                is_addr  <= 1'b1;
                sda_oe   <= 1'b0;
                byte_pos <= '0;
            end else if (stop_det) begin
                state  <= LS_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    LS_RX: begin
                        if (scl_rise && bit_cnt != BITS) begin
                            rx_shift <= {rx_shift[6:0], sda_s};
                            bit_cnt  <= bit_cnt + 4'd1;
                        end else if (scl_fall && bit_cnt == BITS) begin
                            if (is_addr) begin
                                if (rx_shift[7:1] == DEV_ADDR) begin
                                    is_addr <= 1'b0;
                                    rd_mode <= rx_shift[0];
                                    sda_oe  <= 1'b1;
                                    state   <= LS_ACK;
                                end else begin
                                    state <= LS_IDLE;
                                end
                            end else begin
                                sda_oe <= 1'b1;
                                state  <= LS_ACK;
                                if (data_slot) begin
                                    wr_en   <= 1'b1;
                                    wr_idx  <= data_pos[IDX_W-1:0];
                                    wr_data <= rx_shift;
                                end
                                if (!pos_full) begin
                                    byte_pos <= byte_pos + POS_W'(1);
                                end
                            end
                        end
                    end
                    LS_ACK: begin
                        if (scl_fall) begin
                            if (rd_mode) begin
                                tx_shift <= rd_byte;
                                sda_oe   <= ~rd_byte[7];
                                bit_cnt  <= 4'd1;
                                state    <= LS_TX;
                                if (!pos_full) begin
                                    byte_pos <= byte_pos + POS_W'(1);
                                end
                            end else begin
                                sda_oe  <= 1'b0;
                                bit_cnt <= '0;
                                state   <= LS_RX;
                            end
                        end
                    end
                    LS_TX: begin
                        if (scl_fall) begin
                            if (bit_cnt == BITS) begin
                                sda_oe <= 1'b0;
                                state  <= LS_ACK_IN;
                            end else begin
                                tx_shift <= {tx_shift[6:0], 1'b1};
                                sda_oe   <= ~tx_shift[6];
                                bit_cnt  <= bit_cnt + 4'd1;
                            end
                        end
                    end
                    LS_ACK_IN: begin
                        if (scl_rise) begin
                            state <= sda_s ? LS_IDLE : LS_ACK;
                        end
                    end
                    default: begin
                        state <= LS_IDLE;
                    end
                endcase
            end
        end
    end

    // R9
    oe_stable_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_oe));

    // R10
    commit_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !scl_s);

    // R11
    wr_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_idx) < NREG));

    // R4
    commit_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> sda_oe);

endmodule

// File: rtl/clkcfg_regfile.sv
// Register file: holds the configuration bytes, loads them from the link
// and assembles the read stream (count byte, registers, then 0xFF fill).
// Assumes NREG covers the indices named in clkcfg_pkg.
module clkcfg_regfile
    import clkcfg_pkg::*;
#(
    parameter int NREG  = CFG_REG_COUNT,
    parameter int POS_W = $clog2(NREG + 3) + 1,
    parameter int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [POS_W-1:0] rd_pos,
    output logic [7:0]       rd_byte,
    output logic [7:0]       en_misc_byte,
    output logic [7:0]       en_pci_byte,
    output logic [7:0]       mode_byte
);

    logic [NREG-1:0][7:0] regs;

    // Register storage with per-index power-on values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NREG; k++) begin
                regs[k] <= cfg_reset_value(k);
            end
        end else if (wr_en) begin
            for (int k = 0; k < NREG; k++) begin
                if (wr_idx == IDX_W'(k)) begin
                    regs[k] <= wr_data;
                end
            end
        end
    end

    // Read stream mux: position 0 is the count, then registers, then fill.
    always_comb begin
        rd_byte = 8'hFF;
        if (rd_pos == '0) begin
            rd_byte = 8'(NREG);
        end
        for (int k = 0; k < NREG; k++) begin
            if (rd_pos == POS_W'(k + 1)) begin
                rd_byte = regs[k];
            end
        end
    end

    assign en_misc_byte = regs[CFG_EN_MISC_IDX];
    assign en_pci_byte  = regs[CFG_EN_PCI_IDX];
    assign mode_byte    = regs[CFG_MODE_IDX];

endmodule

// File: rtl/clkcfg_i2c_target.sv
// Top: I2C target holding the clock generator configuration bytes.
// Wires the bus sampler, link controller and register file together and
// decodes the control bytes into named outputs. Assumes NREG > 6.
module clkcfg_i2c_target
    import clkcfg_pkg::*;
#(
    parameter int         NREG        = CFG_REG_COUNT,
    parameter logic [6:0] DEV_ADDR    = CFG_DEV_ADDR,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic [7:0] clk_en_misc,
    output logic [7:0] clk_en_pci,
    output logic       spread_en,
    output logic [4:0] freq_code,
    output logic       freq_from_reg,
    output logic       sdram_ref_en
);

    localparam int POS_W = $clog2(NREG + 3) + 1;
    localparam int IDX_W = $clog2(NREG);

    logic             scl_s;
    logic             sda_s;
    logic             scl_rise;
    logic             scl_fall;
    logic             start_det;
    logic             stop_det;
    logic [7:0]       rd_byte;
    logic [POS_W-1:0] rd_pos;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [7:0]       wr_data;
    logic [7:0]       mode_byte;

    clkcfg_bus_sampler #(
        .SYNC_STAGES (SYNC_STAGES)
    ) sampler_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    clkcfg_link #(
        .NREG     (NREG),
        .DEV_ADDR (DEV_ADDR),
        .POS_W    (POS_W),
        .IDX_W    (IDX_W)
    ) link_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_byte   (rd_byte),
        .rd_pos    (rd_pos),
        .sda_oe    (sda_oe),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data)
    );

    clkcfg_regfile #(
        .NREG  (NREG),
        .POS_W (POS_W),
        .IDX_W (IDX_W)
    ) regs_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_idx       (wr_idx),
        .wr_data      (wr_data),
        .rd_pos       (rd_pos),
        .rd_byte      (rd_byte),
        .en_misc_byte (clk_en_misc),
        .en_pci_byte  (clk_en_pci),
        .mode_byte    (mode_byte)
    );

    // Decode the mode byte into its control fields.
    always_comb begin
        spread_en     = mode_byte[7];
        freq_code     = mode_byte[6:2];
        freq_from_reg = mode_byte[1];
        sdram_ref_en  = mode_byte[0];
    end

endmodule

// File: tb/clkcfg_i2c_target_tb_top.sv
// Scoreboard bench: driver tasks push expected items, the monitor pops and
// compares them against values observed on the bus and outputs.
module clkcfg_i2c_target_tb_top;

    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic tb_sda_low = 1'b0;
    logic sda_line;
    logic sda_oe;
    logic [7:0] clk_en_misc;
    logic [7:0] clk_en_pci;
    logic spread_en;
    logic [4:0] freq_code;
    logic freq_from_reg;
    logic sdram_ref_en;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    string exp_req_q[$];
    logic [7:0] exp_val_q[$];
    logic [7:0] obs_val_q[$];

    always #2 clk = ~clk;

    assign sda_line = ~(tb_sda_low | sda_oe);

    clkcfg_i2c_target dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_i         (scl),
        .sda_i         (sda_line),
        .sda_oe        (sda_oe),
        .clk_en_misc   (clk_en_misc),
        .clk_en_pci    (clk_en_pci),
        .spread_en     (spread_en),
        .freq_code     (freq_code),
        .freq_from_reg (freq_from_reg),
        .sdram_ref_en  (sdram_ref_en)
    );

    // Monitor: pops matched expected/observed pairs and compares them.
    initial begin
        forever begin
            @(negedge clk);
            while (exp_val_q.size() > 0 && obs_val_q.size() > 0) begin
                string r;
                logic [7:0] e;
                logic [7:0] a;
                r = exp_req_q.pop_front();
                e = exp_val_q.pop_front();
                a = obs_val_q.pop_front();
                checks++;
                if (a !== e) begin
                    fails++;
                    $display("FAIL %s actual=%02h expected=%02h", r, a, e);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        forever begin
            @(negedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                fails++;
                $display("FAIL watchdog actual=%0d expected<150000 cycles", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string r, input logic [7:0] e, input logic [7:0] a);
        exp_req_q.push_back(r);
        exp_val_q.push_back(e);
        obs_val_q.push_back(a);
    endtask

    task automatic bus_start();
        tb_sda_low = 1'b0; wq(Q);
        scl = 1'b1; wq(Q);
        tb_sda_low = 1'b1; wq(Q);
        scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        tb_sda_low = 1'b1; wq(Q);
        scl = 1'b1; wq(Q);
        tb_sda_low = 1'b0; wq(2 * Q);
    endtask

    task automatic send_bit(input logic b);
        tb_sda_low = ~b; wq(Q);
        scl = 1'b1; wq(2 * Q);
        scl = 1'b0; wq(Q);
    endtask

    task automatic recv_bit(output logic b);
        tb_sda_low = 1'b0; wq(Q);
        scl = 1'b1; wq(Q);
        b = sda_line; wq(Q);
        scl = 1'b0; wq(Q);
    endtask

    task automatic write_byte(input logic [7:0] v, output logic ack);
        logic line;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(line);
        ack = ~line;
    endtask

    task automatic read_byte(output logic [7:0] v, input logic give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
        send_bit(~give_ack);
    endtask

    task automatic wr_expect_ack(input string r, input logic [7:0] v);
        logic ack;
        write_byte(v, ack);
        check(r, 8'd1, {7'd0, ack});
    endtask

    task automatic rd_expect(input string r, input logic [7:0] e, input logic give_ack);
        logic [7:0] v;
        read_byte(v, give_ack);
        check(r, e, v);
    endtask

    // Reads the whole stream and compares it with an expected image.
    task automatic read_all(input string r, input logic [7:0] img [7]);
        bus_start();
        wr_expect_ack("R2", 8'hD3);
        rd_expect("R8", 8'd7, 1'b1);
        for (int k = 0; k < 7; k++) rd_expect(r, img[k], 1'b1);
        rd_expect("R8", 8'hFF, 1'b0);
        wq(2);
        check("R9", 8'd0, {7'd0, sda_oe});
        bus_stop();
        check("R9", 8'd0, {7'd0, sda_oe});
    endtask

    initial begin
        logic [7:0] img [7];
        logic ack;
        wq(5);
        rst_n = 1'b1;
        wq(5);

        // R1 reset values at the outputs
        check("R1", 8'hFF, clk_en_misc);
        check("R1", 8'hFF, clk_en_pci);
        check("R1", 8'h00, {7'd0, spread_en});
        check("R1", 8'h08, {3'd0, freq_code});
        check("R1", 8'h00, {7'd0, freq_from_reg});
        check("R1", 8'h01, {7'd0, sdram_ref_en});
        img = '{8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'hFF, 8'h21};
        read_all("R1", img);

        // R3 framing bytes discarded, R4 ascending load, R11 extra byte acked
        bus_start();
        wr_expect_ack("R2", 8'hD2);
        wr_expect_ack("R3", 8'h77);
        wr_expect_ack("R3", 8'h33);
        wr_expect_ack("R4", 8'h11);
        wr_expect_ack("R4", 8'h22);
        wr_expect_ack("R4", 8'h33);
        wr_expect_ack("R4", 8'h44);
        wr_expect_ack("R4", 8'hA5);
        wr_expect_ack("R4", 8'h3C);
        wr_expect_ack("R4", 8'hDA);
        wr_expect_ack("R11", 8'h00);
        bus_stop();
        wq(20);
        check("R5", 8'hA5, clk_en_misc);
        check("R6", 8'h3C, clk_en_pci);
        check("R7", 8'h01, {7'd0, spread_en});
        check("R7", 8'h16, {3'd0, freq_code});
        check("R7", 8'h01, {7'd0, freq_from_reg});
        check("R7", 8'h00, {7'd0, sdram_ref_en});
        img = '{8'h11, 8'h22, 8'h33, 8'h44, 8'hA5, 8'h3C, 8'hDA};
        read_all("R4", img);

        // R4 partial burst: later registers keep their values
        bus_start();
        wr_expect_ack("R2", 8'hD2);
        wr_expect_ack("R3", 8'h00);
        wr_expect_ack("R3", 8'h00);
        wr_expect_ack("R4", 8'hE1);
        wr_expect_ack("R4", 8'hE2);
        bus_stop();
        img = '{8'hE1, 8'hE2, 8'h33, 8'h44, 8'hA5, 8'h3C, 8'hDA};
        read_all("R4", img);

        // R2 foreign address: no ack, following bytes not stored
        bus_start();
        write_byte(8'hA4, ack);
        check("R2", 8'd0, {7'd0, ack});
        write_byte(8'h00, ack);
        check("R2", 8'd0, {7'd0, ack});
        write_byte(8'h00, ack);
        write_byte(8'h00, ack);
        check("R2", 8'd0, {7'd0, ack});
        bus_stop();
        wq(20);
        check("R2", 8'hA5, clk_en_misc);
        check("R2", 8'h3C, clk_en_pci);

        // R10 STOP in the middle of a data byte discards it
        bus_start();
        wr_expect_ack("R2", 8'hD2);
        wr_expect_ack("R3", 8'h00);
        wr_expect_ack("R3", 8'h00);
        wr_expect_ack("R10", 8'h0F);
        send_bit(1'b1);
        send_bit(1'b0);
        send_bit(1'b1);
        send_bit(1'b0);
        bus_stop();
        img = '{8'h0F, 8'hE2, 8'h33, 8'h44, 8'hA5, 8'h3C, 8'hDA};
        read_all("R10", img);

        // R12 repeated START turns a write into a read
        bus_start();
        wr_expect_ack("R2", 8'hD2);
        wr_expect_ack("R3", 8'h00);
        wr_expect_ack("R3", 8'h00);
        wr_expect_ack("R12", 8'h99);
        bus_start();
        wr_expect_ack("R12", 8'hD3);
        rd_expect("R12", 8'd7, 1'b1);
        rd_expect("R12", 8'h99, 1'b1);
        rd_expect("R12", 8'hE2, 1'b0);
        bus_stop();

        wq(10);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule